// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the four-state coherence state (Modified, Exclusive, Shared, Invalid) for each line of one private cache that sits on a shared snooping bus. The local processor side presents read, write and evict requests for a line index. Another part of the cache does the tag lookup and supplies that index. When a request needs a bus transaction, the controller raises it and waits for a grant. A read miss, a write from Invalid, an upgrade of a Shared line and the writeback of an evicted dirty line all need one. Requests that need no transaction complete in the cycle they are presented.

The bus side takes in the transactions that other caches put on the bus, one per cycle and in bus order. For each one it answers in the same cycle with two signals. The first says this cache holds a copy. The second asks the data path to write the dirty line back. The controller then updates that line's state at the clock edge. When its own read is granted, it samples a wired shared-line input to choose between Exclusive and Shared. Data arrays, tags, replacement and arbitration live outside the block. Only one of the block's transactions is on the bus at a time, because the local interface carries a single request.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any line raises a bus read (command code 0).
- R2: A read of an Invalid line raises bus read code 0. When it is granted with the shared-line input low, the line becomes Exclusive.
- R3: A read of an Invalid line granted with the shared-line input high becomes Shared.
- R4: A read of a Modified, Exclusive or Shared line completes in the cycle it is presented, with no bus request and no state change.
- R5: A write always leaves the line Modified. From Invalid it raises read-for-ownership (code 1). From Shared it raises upgrade (code 2). From Exclusive or Modified it raises no bus request.
- R6: A snooped bus read (code 0) of a Modified line asserts the flush output and the shared output, and the line becomes Shared. The same snoop on an Exclusive or Shared line asserts shared only and leaves the line Shared. On an Invalid line it asserts neither.
- R7: A snooped read-for-ownership (code 1) or upgrade (code 2) moves a valid line to Invalid. Flush is asserted only if the line was Modified. Shared is not asserted.
- R8: Evicting a Modified line raises a writeback (code 3) and leaves the line Invalid. Evicting any other state is silent and leaves it Invalid. A snooped writeback changes nothing.
- R9: In a cycle with a snoop, no local request completes. The pending bus command is derived from the line's current state, so an upgrade that loses its line to a snooped invalidation is reissued as read-for-ownership.
- R10: A snoop or local request changes only the line whose index it carries.
- R11: Local request handshake is valid/ready: a request is taken when req_valid and req_ready are both high. The requester must hold op and index until then. A request that needs the bus keeps bus_req_valid high and req_ready low until bus_gnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request completes this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| req_idx | input | IDX_W | Line index of the local request |
| bus_req_valid | output | 1 | Bus transaction wanted |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_req_idx | output | IDX_W | Line index of the bus transaction |
| bus_gnt | input | 1 | Bus transaction performed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled on granted reads) |
| snp_valid | input | 1 | Another cache's transaction on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_req_cmd |
| snp_idx | input | IDX_W | Snooped line index |
| snp_shared | output | 1 | This cache holds a copy of the snooped line |
| snp_flush | output | 1 | Write the snooped dirty line back now |

## Verification
The bench builds two instances with LINES=4 on a modelled bus. A fixed-priority grant joins them, each instance's transaction is the other's snoop, and each instance's snp_shared feeds the other's shared input. Every sequence of three operations drawn from read, write and evict on either cache is run on each of the four lines, then both copies are evicted. This covers every reachable pair of line states and every transition between them. Directed runs add a grant held off for several cycles, and an upgrade that loses its line to the peer's same-cycle write.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BUS_RD = 2'd0, BUS_RDX = 2'd1, BUS_UPG = 2'd2, BUS_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EVICT = 2'd2, OP_NOP = 2'd3} loc_op_t;
endpackage

// File: rtl/coh_local_fsm.sv
module coh_local_fsm
  import coh_pkg::*;
(
  input  line_st_t cur,
  input  loc_op_t  op,
  input  logic     shared_in,
  output logic     need_bus,
  output bus_cmd_t cmd,
  output line_st_t nxt
);
  always_comb begin
    need_bus = 1'b0;
    cmd      = BUS_RD;
    nxt      = cur;
    unique case (op)
      OP_RD: begin
        if (cur == ST_I) begin
          need_bus = 1'b1;
          cmd      = BUS_RD;
          nxt      = shared_in ? ST_S : ST_E;
        end
      end
      OP_WR: begin
        nxt = ST_M;
        if (cur == ST_I) begin
          need_bus = 1'b1;
          cmd      = BUS_RDX;
        end else if (cur == ST_S) begin
          need_bus = 1'b1;
          cmd      = BUS_UPG;
        end
      end
      OP_EVICT: begin
        nxt = ST_I;
        if (cur == ST_M) begin
          need_bus = 1'b1;
          cmd      = BUS_WB;
        end
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
  import coh_pkg::*;
(
  input  line_st_t cur,
  input  bus_cmd_t cmd,
  output line_st_t nxt,
  output logic     shared_out,
  output logic     flush
);
  always_comb begin
    nxt        = cur;
    shared_out = 1'b0;
    flush      = 1'b0;
    unique case (cmd)
      BUS_RD: begin
        if (cur != ST_I) begin
          shared_out = 1'b1;
          flush      = (cur == ST_M);
          nxt        = ST_S;
        end
      end
      BUS_RDX, BUS_UPG: begin
        flush = (cur == ST_M);
        nxt   = ST_I;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/coh_line_reg.sv
module coh_line_reg
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld,
  input  line_st_t d,
  output line_st_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= ST_I;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_cmd,
  output logic [IDX_W-1:0] bus_req_idx,
  input  logic             bus_gnt,
  input  logic             bus_shared_in,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_shared,
  output logic             snp_flush
);
  line_st_t [LINES-1:0] line_st;
  line_st_t             loc_cur, loc_nxt, snp_cur, snp_nxt;
  bus_cmd_t             loc_cmd;
  logic                 loc_need, loc_done, sf_shared, sf_flush;

  assign loc_cur = line_st[req_idx];
  assign snp_cur = line_st[snp_idx];

  coh_local_fsm u_local (
    .cur       (loc_cur),
    .op        (loc_op_t'(req_op)),
    .shared_in (bus_shared_in),
    .need_bus  (loc_need),
    .cmd       (loc_cmd),
    .nxt       (loc_nxt)
  );

  coh_snoop_fsm u_snoop (
    .cur        (snp_cur),
    .cmd        (bus_cmd_t'(snp_cmd)),
    .nxt        (snp_nxt),
    .shared_out (sf_shared),
    .flush      (sf_flush)
  );

  // Snoops are ordered ahead of local completion: a snoop cycle stalls the requester.
  assign bus_req_valid = req_valid && loc_need;
  assign bus_req_cmd   = loc_cmd;
  assign bus_req_idx   = req_idx;
  assign req_ready     = !snp_valid && (!loc_need || bus_gnt);
  assign loc_done      = req_valid && req_ready;
  assign snp_shared    = snp_valid && sf_shared;
  assign snp_flush     = snp_valid && sf_flush;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic     snp_hit, loc_hit;
    line_st_t d;
    assign snp_hit = snp_valid && (snp_idx == IDX_W'(g));
    assign loc_hit = loc_done && (req_idx == IDX_W'(g));
    assign d       = snp_hit ? snp_nxt : loc_nxt;
    coh_line_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (snp_hit || loc_hit),
      .d     (d),
      .q     (line_st[g])
    );
  end
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_op,
  input logic [IDX_W-1:0]     req_idx,
  input logic                 bus_req_valid,
  input logic                 snp_valid,
  input logic [1:0]           snp_cmd,
  input logic [IDX_W-1:0]     snp_idx,
  input logic                 snp_flush,
  input line_st_t [LINES-1:0] line_st
);
  // R9
  snoop_blocks_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready);
  // R6
  flush_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && line_st[snp_idx] == ST_M));
  // R5
  write_lands_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_WR) |=> line_st[$past(req_idx)] == ST_M);
  // R5
  excl_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WR && line_st[req_idx] == ST_E) |-> !bus_req_valid);
  // R7
  snoop_own_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_cmd == BUS_RDX || snp_cmd == BUS_UPG)) |=> line_st[$past(snp_idx)] == ST_I);
  // R8
  evict_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_EVICT) |=> line_st[$past(req_idx)] == ST_I);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .req_idx       (req_idx),
  .bus_req_valid (bus_req_valid),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_idx       (snp_idx),
  .snp_flush     (snp_flush),
  .line_st       (line_st)
);

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;
  localparam int CLK_P = 10;
  localparam int LINES = 4;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          a_rv = 0, b_rv = 0, hold_a = 0, hold_b = 0;
  logic [1:0]    a_op = 0, b_op = 0;
  logic [IW-1:0] a_ix = 0, b_ix = 0;
  logic          a_rr, b_rr, a_bv, b_bv, a_sh, b_sh, a_fl, b_fl, a_gnt, b_gnt;
  logic [1:0]    a_cmd, b_cmd;
  logic [IW-1:0] a_bix, b_bix;

  assign a_gnt = a_bv && !hold_a;
  assign b_gnt = b_bv && !hold_b && !a_gnt;

  coh_line_ctrl #(.LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_ready(a_rr), .req_op(a_op), .req_idx(a_ix),
    .bus_req_valid(a_bv), .bus_req_cmd(a_cmd), .bus_req_idx(a_bix), .bus_gnt(a_gnt),
    .bus_shared_in(b_sh), .snp_valid(b_gnt), .snp_cmd(b_cmd), .snp_idx(b_bix),
    .snp_shared(a_sh), .snp_flush(a_fl));

  coh_line_ctrl #(.LINES(LINES)) dut_peer (
    .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_ready(b_rr), .req_op(b_op), .req_idx(b_ix),
    .bus_req_valid(b_bv), .bus_req_cmd(b_cmd), .bus_req_idx(b_bix), .bus_gnt(b_gnt),
    .bus_shared_in(a_sh), .snp_valid(a_gnt), .snp_cmd(a_cmd), .snp_idx(a_bix),
    .snp_shared(b_sh), .snp_flush(b_fl));

  int vectors = 0, miscompares = 0;
  logic [1:0] mst [2][LINES];

  task automatic chk(string rq, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // One operation on cache c (0 = dut, 1 = dut_peer), completed in one cycle.
  task automatic step_op(int c, logic [1:0] op, int ix, string tag);
    int o = 1 - c;
    logic [1:0] cs = mst[c][ix], os = mst[o][ix];
    bit eb = 0; int ec = 0; bit ef = 0, esh = 0;
    string rq = "R4";
    logic bv, rr, fl, sh; logic [1:0] cm;
    case (op)
      2'd0: if (cs == 2'd0) begin eb = 1; ec = 0; ef = (os == 2'd3); esh = (os != 2'd0);
                              rq = (os != 2'd0) ? "R3" : "R2"; end
      2'd1: begin rq = "R5";
              if (cs == 2'd0) begin eb = 1; ec = 1; ef = (os == 2'd3); end
              else if (cs == 2'd1) begin eb = 1; ec = 2; end
            end
      default: begin rq = "R8"; if (cs == 2'd3) begin eb = 1; ec = 3; end end
    endcase
    if (tag != "") rq = tag;
    @(negedge clk);
    if (c == 0) begin a_rv = 1; a_op = op; a_ix = IW'(ix); end
    else        begin b_rv = 1; b_op = op; b_ix = IW'(ix); end
    #1;
    bv = c ? b_bv : a_bv; rr = c ? b_rr : a_rr; cm = c ? b_cmd : a_cmd;
    fl = c ? a_fl : b_fl; sh = c ? a_sh : b_sh;
    chk(rq, "bus_req_valid", int'(bv), int'(eb));
    if (eb) chk(rq, "bus_req_cmd", int'(cm), ec);
    chk("R11", "req_ready", int'(rr), 1);
    chk(op == 2'd0 ? "R6" : "R7", "peer snp_flush", int'(fl), int'(ef));
    chk(op == 2'd0 ? "R6" : "R7", "peer snp_shared", int'(sh), int'(esh));
    @(posedge clk); #1;
    a_rv = 0; b_rv = 0;
    case (op)
      2'd0: if (cs == 2'd0) begin mst[c][ix] = esh ? 2'd1 : 2'd2; if (os != 2'd0) mst[o][ix] = 2'd1; end
      2'd1: begin mst[c][ix] = 2'd3; mst[o][ix] = 2'd0; end
      default: mst[c][ix] = 2'd0;
    endcase
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int l = 0; l < LINES; l++) mst[c][l] = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: first read of every line misses.
    for (int l = 0; l < LINES; l++) step_op(0, 2'd0, l, "R1");
    for (int l = 0; l < LINES; l++) step_op(0, 2'd2, l, "R8");
    // R10: sweep every line with all three-step sequences, lines sharing state in the model.
    for (int l = 0; l < LINES; l++)
      for (int s = 0; s < 216; s++) begin
        step_op((s / 3) % 2,  2'((s % 3)),       l, "");
        step_op((s / 18) % 2, 2'(((s / 6) % 3)), l, "");
        step_op((s / 108) % 2,2'(((s / 36) % 3)), l, "");
        step_op(0, 2'd2, l, "");
        step_op(1, 2'd2, l, "");
      end
    // R10: a dirty line survives traffic on neighbours.
    step_op(0, 2'd1, 3, "R5");
    step_op(1, 2'd1, 0, "R5");
    step_op(1, 2'd0, 2, "R10");
    step_op(0, 2'd0, 3, "R10");
    step_op(1, 2'd0, 3, "R6");
    // R9: upgrade loses its line to the peer's write and is reissued.
    step_op(0, 2'd0, 1, "R2");
    step_op(1, 2'd0, 1, "R3");
    @(negedge clk);
    hold_a = 1; a_rv = 1; a_op = 2'd1; a_ix = 1; b_rv = 1; b_op = 2'd1; b_ix = 1;
    #1;
    chk("R9", "upgrade cmd", int'(a_cmd), 2);
    chk("R9", "ready in snoop cycle", int'(a_rr), 0);
    chk("R5", "peer upgrade cmd", int'(b_cmd), 2);
    @(posedge clk); #1 b_rv = 0;
    @(negedge clk); hold_a = 0; #1;
    chk("R9", "reissued cmd", int'(a_cmd), 1);
    chk("R7", "peer flush", int'(b_fl), 1);
    chk("R11", "ready on grant", int'(a_rr), 1);
    @(posedge clk); #1 a_rv = 0;
    mst[0][1] = 2'd3; mst[1][1] = 2'd0;
    step_op(1, 2'd0, 1, "R6");
    // R11: held grant keeps the request pending.
    step_op(0, 2'd2, 2, "R8");
    step_op(1, 2'd2, 2, "R8");
    @(negedge clk);
    hold_a = 1; a_rv = 1; a_op = 2'd0; a_ix = 2;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R11", "pending bus_req_valid", int'(a_bv), 1);
      chk("R11", "pending req_ready", int'(a_rr), 0);
      @(negedge clk);
    end
    hold_a = 0; #1;
    chk("R11", "released req_ready", int'(a_rr), 1);
    @(posedge clk); #1 a_rv = 0;
    mst[0][2] = 2'd2;
    step_op(0, 2'd1, 2, "R5");
    step_op(1, 2'd2, 2, "R8");
    step_op(0, 2'd2, 2, "R8");
    finish_run();
  end
endmodule